// File: doc/BRIEF.md
# I2C Memory Slave Front End

This block is the serial protocol engine of a 4096-byte memory that sits on an I2C bus. It oversamples SCL and SDA with the system clock and finds START and STOP conditions. It shifts in the control byte and answers only when the device-type nibble and the three strap bits both match. For a write it collects a two-byte word address and then data bytes. It acknowledges each byte by pulling SDA low through an open-drain enable. Each received data byte goes to a write controller as a one-cycle strobe.

For reads it serves bytes from a combinational memory read port that is indexed by the block's own address counter. Master acknowledges keep the read going. While the write controller reports that an internal write is in progress, the control byte is left unacknowledged, so the master can poll until the write is done. A START at any point drops the current transfer. This is how a random read is made: set the address with a write, then issue a repeated START with a read control byte.

Top module: `serial_mem_port`

## Requirements
- R1: After reset, sda_oe, wr_strobe, wr_commit and addr_load are 0, and mem_addr is 0.
- R2: A control byte is acknowledged only when its bits [7:4] equal 4'b1010 and its bits [3:1] equal strap_i. A mismatch in either field gets no acknowledge, and every later byte is ignored until the next START.
- R3: In a write, the two bytes after the control byte are the high and low word-address bytes, and both are acknowledged. Only bits [3:0] of the high byte are kept. After the low byte, addr_load pulses for one cycle, and in that cycle mem_addr already holds {high[3:0], low}.
- R4: The acknowledge drive (sda_oe) turns on only while SCL is low. It is held through the ninth SCL high phase and released after the ninth falling edge.
- R5: Each data byte that follows the address is acknowledged and produces a one-cycle wr_strobe. In that cycle wr_data is the byte and mem_addr is the target address.
- R6: After each write strobe the address counter advances within a 32-byte page: bits [4:0] wrap and bits [11:5] do not change.
- R7: A STOP that ends a transfer holding at least one accepted data byte produces a one-cycle wr_commit. A STOP after a transfer with no data byte produces none.
- R8: While wr_busy is high, a matching control byte is not acknowledged. Once wr_busy is low again, the same control byte is acknowledged.
- R9: When bit [0] of the control byte is 1, the block sends rd_data for the current mem_addr, MSB first, then advances the counter by one with a wrap over the full 12 bits. A master ACK (SDA low on the ninth clock) starts the next byte. A NACK ends the read with SDA released.
- R10: A START seen in any state, including partway through a byte, drops the transfer. Nothing from the partial byte is written, and control-byte reception begins again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Device address strap pins |
| wr_busy | input | 1 | High while the write controller runs an internal write |
| rd_data | input | 8 | Memory byte at mem_addr |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| mem_addr | output | 12 | Current word address counter |
| wr_strobe | output | 1 | One-cycle pulse per received data byte |
| wr_data | output | 8 | Data byte that goes with wr_strobe |
| wr_commit | output | 1 | One-cycle pulse at STOP when data bytes are pending |
| addr_load | output | 1 | One-cycle pulse when a new word address is loaded |

## Verification
The bench aims at four kinds of corner case:
- A control byte with the right type but the wrong strap, and a wrong type nibble. A loose comparator would acknowledge one of them and then accept the bytes that follow.
- A page write that crosses the 32-byte boundary, and a sequential read that crosses the same boundary and the top of the 12-bit space. A counter with a single increment rule would land on the wrong address in one of the two cases.
- Polling while busy. An engine that ignores wr_busy acknowledges too early.
- A START in the middle of a data byte. An engine that does not abort either writes a garbage byte or misses the new control byte.

// File: rtl/serial_mem_pkg.sv
package serial_mem_pkg;

   typedef enum logic [2:0] {
      LNK_IDLE,
      LNK_CTRL,
      LNK_ADR_HI,
      LNK_ADR_LO,
      LNK_WDATA,
      LNK_RDATA
   } link_state_t;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   localparam int TOP = SYNC_STAGES - 1;

   logic [TOP:0] scl_sh, sda_sh;
   logic         scl_p, sda_p;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("bus_sampler: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[TOP-1:0], scl_i};
         sda_sh <= {sda_sh[TOP-1:0], sda_i};
         scl_p  <= scl_sh[TOP];
         sda_p  <= sda_sh[TOP];
      end
   end

   assign scl_lvl  = scl_sh[TOP];
   assign sda_lvl  = sda_sh[TOP];
   assign scl_rise = scl_lvl & ~scl_p;
   assign scl_fall = ~scl_lvl & scl_p;
   assign start_ev = scl_lvl & scl_p & sda_p & ~sda_lvl;
   assign stop_ev  = scl_lvl & scl_p & ~sda_p & sda_lvl;

endmodule

// File: rtl/word_addr_counter.sv
module word_addr_counter #(
   parameter int ADDR_BITS = 12,
   parameter int PAGE_BITS = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [ADDR_BITS-1:0] load_val,
   input  logic                 inc_page,
   input  logic                 inc_full,
   output logic [ADDR_BITS-1:0] addr
);

   logic [ADDR_BITS-1:0] cnt, page_next;

   generate
      if (PAGE_BITS > 0) begin : g_paged
         logic [PAGE_BITS-1:0] low_inc;
         assign low_inc   = cnt[PAGE_BITS-1:0] + PAGE_BITS'(1);
         assign page_next = {cnt[ADDR_BITS-1:PAGE_BITS], low_inc};

         AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_page && !load && !inc_full) |=>
               (cnt[ADDR_BITS-1:PAGE_BITS] == $past(cnt[ADDR_BITS-1:PAGE_BITS]))); // R6
      end else begin : g_flat
         assign page_next = cnt + ADDR_BITS'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (load)     cnt <= load_val;
      else if (inc_full) cnt <= cnt + ADDR_BITS'(1);
      else if (inc_page) cnt <= page_next;
   end

   assign addr = cnt;

endmodule

// File: rtl/serial_mem_port.sv
module serial_mem_port
   import serial_mem_pkg::*;
#(
   parameter int         ADDR_BITS   = 12,
   parameter int         PAGE_BITS   = 5,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   input  logic [2:0]           strap_i,
   input  logic                 wr_busy,
   input  logic [BYTE_W-1:0]    rd_data,
   output logic                 sda_oe,
   output logic [ADDR_BITS-1:0] mem_addr,
   output logic                 wr_strobe,
   output logic [BYTE_W-1:0]    wr_data,
   output logic                 wr_commit,
   output logic                 addr_load
);

   localparam int HI_BITS = ADDR_BITS - BYTE_W;
   localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

   generate
      if (ADDR_BITS < 9 || ADDR_BITS > 16) begin : g_bad_addr
         $error("serial_mem_port: ADDR_BITS must be 9..16");
      end
      if (PAGE_BITS >= ADDR_BITS) begin : g_bad_page
         $error("serial_mem_port: PAGE_BITS must be below ADDR_BITS");
      end
   endgenerate

   logic scl_lvl, sda_lvl, rise_ev, fall_ev, start_ev, stop_ev;

   bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_lvl  (scl_lvl),
      .sda_lvl  (sda_lvl),
      .scl_rise (rise_ev),
      .scl_fall (fall_ev),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   link_state_t         st;
   logic [3:0]          bitcnt;
   logic                ack_ph;
   logic                pend;
   logic [BYTE_W-1:0]   shreg;
   logic [BYTE_W-2:0]   tx;
   logic [HI_BITS-1:0]  hi_q;

   logic byte_fall, ctrl_hit, cnt_load, cnt_inc_full;

   assign byte_fall    = fall_ev && (bitcnt == LAST_BIT) && !ack_ph;
   assign ctrl_hit     = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap_i) && !wr_busy;
   assign cnt_load     = (st == LNK_ADR_LO) && byte_fall;
   assign cnt_inc_full = (st == LNK_RDATA) && byte_fall;

   word_addr_counter #(.ADDR_BITS(ADDR_BITS), .PAGE_BITS(PAGE_BITS)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val ({hi_q, shreg}),
      .inc_page (wr_strobe),
      .inc_full (cnt_inc_full),
      .addr     (mem_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= LNK_IDLE;
         bitcnt    <= '0;
         ack_ph    <= 1'b0;
         pend      <= 1'b0;
         shreg     <= '0;
         tx        <= '0;
         hi_q      <= '0;
         sda_oe    <= 1'b0;
         wr_strobe <= 1'b0;
         wr_data   <= '0;
         wr_commit <= 1'b0;
         addr_load <= 1'b0;
      end else begin
         wr_strobe <= 1'b0;
         wr_commit <= 1'b0;
         addr_load <= 1'b0;
         if (start_ev) begin
            st     <= LNK_CTRL;
            bitcnt <= '0;
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
         end else if (stop_ev) begin
            st     <= LNK_IDLE;
            bitcnt <= '0;
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
            if (pend) begin
               wr_commit <= 1'b1;
               pend      <= 1'b0;
            end
         end else begin
            case (st)
               LNK_IDLE: ;
               LNK_RDATA: begin
                  if (ack_ph) begin
                     if (fall_ev) begin
                        ack_ph <= 1'b0;
                        bitcnt <= '0;
                        tx     <= rd_data[BYTE_W-2:0];
                        sda_oe <= ~rd_data[BYTE_W-1];
                     end
                  end else if (rise_ev) begin
                     if (bitcnt == LAST_BIT) begin
                        if (sda_lvl) st     <= LNK_IDLE;
                        else         ack_ph <= 1'b1;
                     end else begin
                        bitcnt <= bitcnt + 4'd1;
                     end
                  end else if (fall_ev) begin
                     if (bitcnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                     end else if (bitcnt != 4'd0) begin
                        tx     <= {tx[BYTE_W-3:0], 1'b0};
                        sda_oe <= ~tx[BYTE_W-2];
                     end
                  end
               end
               default: begin
                  if (ack_ph) begin
                     if (fall_ev) begin
                        ack_ph <= 1'b0;
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                     end
                  end else if (rise_ev && bitcnt != LAST_BIT) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (byte_fall) begin
                     case (st)
                        LNK_CTRL: begin
                           if (ctrl_hit) begin
                              ack_ph <= 1'b1;
                              sda_oe <= 1'b1;
                              st     <= shreg[0] ? LNK_RDATA : LNK_ADR_HI;
                           end else begin
                              st <= LNK_IDLE;
                           end
                        end
                        LNK_ADR_HI: begin
                           hi_q   <= shreg[HI_BITS-1:0];
                           ack_ph <= 1'b1;
                           sda_oe <= 1'b1;
                           st     <= LNK_ADR_LO;
                        end
                        LNK_ADR_LO: begin
                           addr_load <= 1'b1;
                           ack_ph    <= 1'b1;
                           sda_oe    <= 1'b1;
                           st        <= LNK_WDATA;
                        end
                        default: begin
                           wr_strobe <= 1'b1;
                           wr_data   <= shreg;
                           pend      <= 1'b1;
                           ack_ph    <= 1'b1;
                           sda_oe    <= 1'b1;
                        end
                     endcase
                  end
               end
            endcase
         end
      end
   end

   AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_lvl); // R4

   AST_BUSY_NOACK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LNK_CTRL && byte_fall && wr_busy) |=> (!sda_oe && st == LNK_IDLE)); // R8

   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |=> !wr_strobe); // R5

   AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> $past(stop_ev)); // R7

   AST_START_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (st == LNK_CTRL && !sda_oe && bitcnt == 4'd0)); // R10

endmodule

// File: tb/tb_serial_mem_port.sv
module tb_serial_mem_port;

   localparam int Q = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        wr_busy = 1'b0;
   logic [2:0]  strap = 3'b101;
   logic [7:0]  rd_data;
   logic        sda_oe, wr_strobe, wr_commit, addr_load;
   logic [11:0] mem_addr;
   logic [7:0]  wr_data;
   logic        sda_bus;

   logic [7:0]  mem_m [0:4095];
   logic [19:0] exp_q [$];
   int          exp_commits = 0;
   logic [11:0] last_load = '0;
   int          n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;
   assign rd_data = mem_m[mem_addr];

   serial_mem_port dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_bus),
      .strap_i   (strap),
      .wr_busy   (wr_busy),
      .rd_data   (rd_data),
      .sda_oe    (sda_oe),
      .mem_addr  (mem_addr),
      .wr_strobe (wr_strobe),
      .wr_data   (wr_data),
      .wr_commit (wr_commit),
      .addr_load (addr_load)
   );

   function automatic logic [7:0] pat(input int a);
      return 8'(a * 7 + 3);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_bit(input bit b);
      sda_m = b;    tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic read_bit(output bit r);
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      r = sda_bus;  tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      bit r;
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      read_bit(r);
      acked = !r;
   endtask

   task automatic read_byte(input bit mack, output logic [7:0] v);
      bit r;
      for (int i = 7; i >= 0; i--) begin
         read_bit(r);
         v[i] = r;
      end
      send_bit(!mack);
   endtask

   task automatic push_wr(input logic [11:0] a, input logic [7:0] d);
      exp_q.push_back({a, d});
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // monitor: scoreboard for write strobes, commits, loads and ack timing
   initial begin
      logic       prev_oe;
      logic [19:0] e;
      for (int a = 0; a < 4096; a++) mem_m[a] = pat(a);
      prev_oe = 1'b0;
      forever begin
         @(negedge clk);
         if (wr_strobe) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5 unexpected wr_strobe", {mem_addr, wr_data}, 0);
            end else begin
               e = exp_q.pop_front();
               chk({mem_addr, wr_data} == e, "R5/R6 write addr,data", {mem_addr, wr_data}, e);
            end
            mem_m[mem_addr] = wr_data;
         end
         if (wr_commit) begin
            chk(exp_commits > 0, "R7 unexpected wr_commit", 1, 0);
            if (exp_commits > 0) exp_commits--;
         end
         if (addr_load) last_load = mem_addr;
         if (sda_oe && !prev_oe) chk(!scl_m, "R4 ack drive while SCL low", scl_m, 0);
         prev_oe = sda_oe;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      bit         ak;
      logic [7:0] v;

      tick(3);
      chk(sda_oe == 1'b0 && wr_strobe == 1'b0 && wr_commit == 1'b0 && addr_load == 1'b0,
          "R1 reset outputs", {sda_oe, wr_strobe, wr_commit, addr_load}, 0);
      chk(mem_addr == 12'h000, "R1 reset address", mem_addr, 0);
      rst_n = 1'b1;
      tick(5);

      // R2: wrong type nibble, then a byte that must be ignored
      bus_start();
      send_byte(8'hBA, ak);
      chk(!ak, "R2 wrong type not acked", ak, 0);
      send_byte(8'h00, ak);
      chk(!ak, "R2 following byte ignored", ak, 0);
      bus_stop();

      // R2: right type, wrong strap
      bus_start();
      send_byte(8'hA0, ak);
      chk(!ak, "R2 wrong strap not acked", ak, 0);
      bus_stop();

      // R3/R5/R6: page write crossing a 32-byte boundary
      bus_start();
      send_byte(8'hAA, ak);
      chk(ak, "R2 matching control acked", ak, 1);
      send_byte(8'hF3, ak);
      chk(ak, "R3 high address acked", ak, 1);
      send_byte(8'h1E, ak);
      chk(ak, "R3 low address acked", ak, 1);
      chk(last_load == 12'h31E, "R3 loaded address", last_load, 12'h31E);
      push_wr(12'h31E, 8'h11);
      send_byte(8'h11, ak);
      chk(ak, "R5 data byte 0 acked", ak, 1);
      push_wr(12'h31F, 8'h22);
      send_byte(8'h22, ak);
      chk(ak, "R5 data byte 1 acked", ak, 1);
      push_wr(12'h300, 8'h33);
      send_byte(8'h33, ak);
      chk(ak, "R6 data byte after page wrap acked", ak, 1);
      exp_commits++;
      bus_stop();
      tick(5);
      chk(exp_commits == 0, "R7 commit after write", exp_commits, 0);

      // R8: busy polling, then R7 no commit without data
      wr_busy = 1'b1;
      bus_start();
      send_byte(8'hAA, ak);
      chk(!ak, "R8 busy control not acked", ak, 0);
      bus_stop();
      wr_busy = 1'b0;
      bus_start();
      send_byte(8'hAA, ak);
      chk(ak, "R8 acked after busy clears", ak, 1);
      bus_stop();
      tick(5);

      // R10/R9: random read through repeated START, crossing the page
      bus_start();
      send_byte(8'hAA, ak);
      send_byte(8'h03, ak);
      send_byte(8'h1E, ak);
      chk(ak, "R3 read setup address acked", ak, 1);
      bus_start();
      send_byte(8'hAB, ak);
      chk(ak, "R10 control after repeated start acked", ak, 1);
      read_byte(1'b1, v);
      chk(v == 8'h11, "R9 read byte 0", v, 8'h11);
      read_byte(1'b1, v);
      chk(v == 8'h22, "R9 read byte 1", v, 8'h22);
      read_byte(1'b0, v);
      chk(v == pat(12'h320), "R9 read crosses page", v, pat(12'h320));
      chk(sda_oe == 1'b0, "R9 released after NACK", sda_oe, 0);
      bus_stop();
      chk(mem_addr == 12'h321, "R9 counter after read", mem_addr, 12'h321);

      // R9: read wrap at top of address space
      bus_start();
      send_byte(8'hAA, ak);
      send_byte(8'h0F, ak);
      send_byte(8'hFF, ak);
      bus_start();
      send_byte(8'hAB, ak);
      read_byte(1'b1, v);
      chk(v == pat(12'hFFF), "R9 read top byte", v, pat(12'hFFF));
      read_byte(1'b0, v);
      chk(v == pat(0), "R9 read wraps to zero", v, pat(0));
      bus_stop();

      // R10: START in the middle of a data byte
      bus_start();
      send_byte(8'hAA, ak);
      send_byte(8'h00, ak);
      send_byte(8'h40, ak);
      for (int i = 0; i < 4; i++) send_bit(1'b0);
      bus_start();
      send_byte(8'hAB, ak);
      chk(ak, "R10 control after mid-byte start acked", ak, 1);
      read_byte(1'b0, v);
      chk(v == pat(12'h40), "R10 partial byte not written", v, pat(12'h40));
      bus_stop();
      tick(10);

      chk(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
      chk(exp_commits == 0, "R7 no missing commit", exp_commits, 0);
      finish_run();
   end

endmodule